// File: doc/BRIEF.md
# Data Access Alignment Fault Detector

This block sits next to a load/store unit and judges every data access it is shown. For each access it receives:

- a valid strobe;
- an operation class: scalar, floating-point, load/store multiple, string, or reservation pair;
- the effective address;
- the access size;
- the little-endian mode bit;
- the raw 32-bit instruction word.

From these it decides whether the access breaks the alignment rules for its class and byte order.

When an access faults, the block raises a one-cycle exception request on the following clock edge. On that same edge it latches two values. The first is a 32-bit syndrome word built from fields of the faulting instruction. The second is the faulting effective address.

The syndrome layout depends on the instruction's form:

- **Indexed form** is recognised by primary opcode 31, that is, instruction bits 0:5 (bit 0 is the MSB).
- **Displacement form** is every other opcode.

Address generation, vectoring and pipeline flushing belong to the surrounding core.

Top module: `align_exc_unit`

## Requirements
- R1: Operation class code 1 (floating-point) faults when effective address bits [1:0] are not 00, in either byte order.
- R2: Operation class code 2 (load/store multiple) faults when address bits [1:0] are not 00, and always faults when the little-endian bit is 1.
- R3: Operation class code 4 (reservation load / conditional store) faults when address bits [1:0] are not 00, in either byte order.
- R4: Operation class code 0 (scalar) faults only when the little-endian bit is 1 and the address is not a multiple of the size. Size codes are 0 byte (never faults), 1 halfword (bit [0]), 2 word (bits [1:0]) and 3 doubleword (bits [2:0]).
- R5: Operation class code 3 (string) faults whenever the little-endian bit is 1 and never when it is 0, whatever the address.
- R6: Operation class codes 5, 6 and 7 never fault.
- R7: An access without the valid strobe never faults and leaves the syndrome and address registers unchanged.
- R8: The exception request is high in the cycle after a faulting valid access, and low in the cycle after any other cycle.
- R9: Syndrome bits 0..14 (MSB numbering, bits [31:17] of the port) are zero. Syndrome bits 22..31 take instruction bits 6..15.
- R10: For indexed form (opcode 31), syndrome bits 15:16 take instruction bits 29:30, bit 17 takes instruction bit 25, and bits 18:21 take instruction bits 21:24.
- R11: For displacement form (any other opcode), syndrome bits 15:16 are 00, bit 17 takes instruction bit 5, and bits 18:21 take instruction bits 1:4.
- R12: On a fault the address register captures the effective address of that access.
- R13: Synchronous reset clears the exception request, the syndrome register and the address register. The registers hold their value in every cycle without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | Qualifies the access in this cycle |
| op_class_i | input | 3 | Operation class code |
| eff_addr_i | input | AW | Effective address of the access |
| acc_size_i | input | 2 | Access size code |
| le_mode_i | input | 1 | Little-endian mode bit |
| instr_i | input | 32 | Raw instruction word, bit 0 = MSB |
| exc_req_o | output | 1 | One-cycle alignment exception request |
| syndrome_o | output | 32 | Captured syndrome word |
| fault_addr_o | output | AW | Captured faulting effective address |

## Verification
The bench sweeps every combination of the following:

- operation class code;
- low three address bits;
- size code;
- byte order.

This separates the per-class rules from one another. It also separates the scalar rule's dependence on size and byte order from the unconditional string rule.

Each access carries a fresh pseudo-random instruction word. Its opcode alternates between 31 and displacement opcodes, so every syndrome field is checked under both gathering rules with varied bit contents.

Non-faulting accesses, accesses with the strobe dropped, and a lone fault followed by idle cycles show that the registers hold and that the request is a single pulse.

// File: rtl/align_pkg.sv
package align_pkg;

    typedef enum logic [2:0] {
        OP_SCALAR = 3'd0,
        OP_FLOAT  = 3'd1,
        OP_MULTI  = 3'd2,
        OP_STRING = 3'd3,
        OP_RESV   = 3'd4
    } op_class_e;

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_HALF   = 2'd1,
        SZ_WORD   = 2'd2,
        SZ_DOUBLE = 2'd3
    } acc_size_e;

    localparam int unsigned INSTR_W     = 32;
    localparam int unsigned SYN_W       = 32;
    localparam int unsigned LOWBITS_W   = 3;
    localparam logic [5:0]  OPC_INDEXED = 6'd31;

    // Syndrome fields, listed from MSB to LSB.
    typedef struct packed {
        logic [14:0] zeros;   // syndrome bits 0..14
        logic [1:0]  ext_lo;  // syndrome bits 15..16
        logic        upd;     // syndrome bit 17
        logic [3:0]  kind;    // syndrome bits 18..21
        logic [9:0]  regs;    // syndrome bits 22..31
    } syndrome_t;

    // Mask of the address bits that must be zero for natural alignment.
    function automatic logic [LOWBITS_W-1:0] natural_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: natural_mask = 3'b000;
            SZ_HALF: natural_mask = 3'b001;
            SZ_WORD: natural_mask = 3'b011;
            default: natural_mask = 3'b111;
        endcase
    endfunction

    // Instruction bit j in MSB-first numbering.
    function automatic logic ibit(input logic [INSTR_W-1:0] w, input int unsigned j);
        ibit = w[INSTR_W-1-j];
    endfunction

endpackage

// File: rtl/align_rule_check.sv
module align_rule_check
    import align_pkg::*;
(
    input  logic [2:0]           op_class,
    input  logic [LOWBITS_W-1:0] addr_lo,
    input  logic [1:0]           size,
    input  logic                 le_mode,
    output logic                 fault
);
    logic word_mis;
    logic nat_mis;

    assign word_mis = |addr_lo[1:0];
    assign nat_mis  = |(addr_lo & natural_mask(size));

    always_comb begin
        case (op_class)
            OP_FLOAT:  fault = word_mis;
            OP_MULTI:  fault = word_mis | le_mode;
            OP_STRING: fault = le_mode;
            OP_RESV:   fault = word_mis;
            OP_SCALAR: fault = le_mode & nat_mis;
            default:   fault = 1'b0;
        endcase
    end

    always_comb begin
        assert_be_scalar_clean_R4: assert (!(op_class == OP_SCALAR && !le_mode) || !fault);
        assert_unused_class_R6:    assert (!(op_class > OP_RESV) || !fault);
    end
endmodule

// File: rtl/align_syn_build.sv
module align_syn_build
    import align_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               indexed,
    output syndrome_t          syn
);
    localparam int unsigned REG_FIRST_BIT = 6;
    localparam int unsigned REG_COUNT     = 10;

    logic [5:0] opcode;
    logic       unused_bits;

    assign opcode      = instr[INSTR_W-1 -: 6];
    assign indexed     = (opcode == OPC_INDEXED);
    assign unused_bits = ^{instr[5:3], instr[0]};

    logic [REG_COUNT-1:0] reg_field;

    // Copy instruction bits 6..15 into syndrome bits 22..31, one bit at a time.
    for (genvar k = 0; k < REG_COUNT; k++) begin : g_regs
        assign reg_field[REG_COUNT-1-k] = ibit(instr, REG_FIRST_BIT + k);
    end

    always_comb begin
        syn.zeros = '0;
        syn.regs  = reg_field;
        if (indexed) begin
            syn.ext_lo = {ibit(instr, 29), ibit(instr, 30)};
            syn.upd    = ibit(instr, 25);
            syn.kind   = {ibit(instr, 21), ibit(instr, 22), ibit(instr, 23), ibit(instr, 24)};
        end else begin
            syn.ext_lo = 2'b00;
            syn.upd    = ibit(instr, 5);
            syn.kind   = {ibit(instr, 1), ibit(instr, 2), ibit(instr, 3), ibit(instr, 4)};
        end
    end

    always_comb begin
        assert_disp_ext_zero_R11: assert (indexed || syn.ext_lo == 2'b00);
    end
endmodule

// File: rtl/align_capture.sv
module align_capture
    import align_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  syndrome_t     syn_in,
    input  logic [AW-1:0] addr_in,
    output logic          exc_req,
    output logic [SYN_W-1:0] syn_q,
    output logic [AW-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            exc_req <= 1'b0;
            syn_q   <= '0;
            addr_q  <= '0;
        end else begin
            exc_req <= fire;
            if (fire) begin
                syn_q  <= syn_in;
                addr_q <= addr_in;
            end
        end
    end

    assert_hold_when_idle_R13: assert property (@(posedge clk) disable iff (rst)
        !exc_req |-> ($stable(syn_q) && $stable(addr_q)));
    assert_addr_capture_R12: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (addr_q == $past(addr_in)));
    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        syn_q[SYN_W-1:17] == '0);
endmodule

// File: rtl/align_exc_unit.sv
module align_exc_unit
    import align_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_valid_i,
    input  logic [2:0]          op_class_i,
    input  logic [AW-1:0]       eff_addr_i,
    input  logic [1:0]          acc_size_i,
    input  logic                le_mode_i,
    input  logic [INSTR_W-1:0]  instr_i,
    output logic                exc_req_o,
    output logic [SYN_W-1:0]    syndrome_o,
    output logic [AW-1:0]       fault_addr_o
);
    logic      rule_fault;
    logic      fire;
    logic      is_indexed;
    syndrome_t syn_now;
    logic      unused_idx;

    align_rule_check u_rule (
        .op_class (op_class_i),
        .addr_lo  (eff_addr_i[LOWBITS_W-1:0]),
        .size     (acc_size_i),
        .le_mode  (le_mode_i),
        .fault    (rule_fault)
    );

    align_syn_build u_syn (
        .instr   (instr_i),
        .indexed (is_indexed),
        .syn     (syn_now)
    );

    assign unused_idx = is_indexed;
    assign fire       = acc_valid_i & rule_fault;

    align_capture #(.AW(AW)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .syn_in  (syn_now),
        .addr_in (eff_addr_i),
        .exc_req (exc_req_o),
        .syn_q   (syndrome_o),
        .addr_q  (fault_addr_o)
    );

    assert_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
        exc_req_o |-> $past(acc_valid_i));
    assert_float_mis_R1: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && op_class_i == OP_FLOAT && eff_addr_i[1:0] != 2'b00) |=> exc_req_o);
    assert_string_le_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && op_class_i == OP_STRING && le_mode_i) |=> exc_req_o);
    assert_no_fault_no_req_R8: assert property (@(posedge clk) disable iff (rst)
        !acc_valid_i |=> !exc_req_o);
endmodule

// File: tb/align_exc_unit_tb.sv
module align_exc_unit_tb;
    localparam int unsigned AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_valid_i = 1'b0;
    logic [2:0]    op_class_i = '0;
    logic [AW-1:0] eff_addr_i = '0;
    logic [1:0]    acc_size_i = '0;
    logic          le_mode_i = 1'b0;
    logic [31:0]   instr_i = '0;
    logic          exc_req_o;
    logic [31:0]   syndrome_o;
    logic [AW-1:0] fault_addr_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_syn  = '0;
    logic [AW-1:0] exp_dar = '0;
    logic [31:0] rng = 32'h1234_5677;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    align_exc_unit #(.AW(AW)) u_dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit model_fault(input int op, input logic [2:0] lo, input int sz, input bit le);
        int span;
        span = 1 << sz;
        case (op)
            1: return (lo % 4) != 0;
            2: return le || ((lo % 4) != 0);
            3: return le;
            4: return (lo % 4) != 0;
            0: return le && ((lo % span) != 0);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] model_syn(input logic [31:0] w);
        logic [31:0] s;
        bit x;
        s = '0;
        x = (w[31:26] == 6'd31);
        for (int k = 22; k <= 31; k++) s[31-k] = w[31-(k-16)];
        if (x) begin
            s[31-15] = w[31-29];
            s[31-16] = w[31-30];
            s[31-17] = w[31-25];
            for (int k = 18; k <= 21; k++) s[31-k] = w[31-(k+3)];
        end else begin
            s[31-17] = w[31-5];
            for (int k = 18; k <= 21; k++) s[31-k] = w[31-(k-17)];
        end
        return s;
    endfunction

    function automatic string rule_tag(input int op);
        case (op)
            0: return "R4";
            1: return "R1";
            2: return "R2";
            3: return "R5";
            4: return "R3";
            default: return "R6";
        endcase
    endfunction

    // Drive at a falling edge, then check at the next falling edge.
    task automatic access(input bit v, input int op, input logic [AW-1:0] a,
                          input int sz, input bit le, input logic [31:0] w, input string tag);
        bit f;
        acc_valid_i = v;
        op_class_i  = op[2:0];
        eff_addr_i  = a;
        acc_size_i  = sz[1:0];
        le_mode_i   = le;
        instr_i     = w;
        f = v && model_fault(op, a[2:0], sz, le);
        if (f) begin
            exp_syn = model_syn(w);
            exp_dar = a;
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R8 request"}, 64'(exc_req_o), 64'(f));
        chk(f ? (w[31:26] == 6'd31 ? "R10 syndrome" : "R11 syndrome") : "R13 syndrome hold",
            64'(syndrome_o), 64'(exp_syn));
        chk(f ? "R12 address" : "R13 address hold", 64'(fault_addr_o), 64'(exp_dar));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R13 reset request", 64'(exc_req_o), 64'd0);
        chk("R13 reset syndrome", 64'(syndrome_o), 64'd0);
        chk("R13 reset address", 64'(fault_addr_o), 64'd0);

        for (int op = 0; op < 8; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int le = 0; le < 2; le++)
                    for (int lo = 0; lo < 8; lo++) begin
                        logic [31:0] w;
                        logic [AW-1:0] a;
                        rng = rng ^ (rng << 13);
                        rng = rng ^ (rng >> 17);
                        rng = rng ^ (rng << 5);
                        w = rng;
                        w[31:26] = lo[0] ? 6'd31 : 6'(32 + op * 4 + sz);
                        a = {rng[31:3] ^ AW'(op * 1000 + sz), 3'(lo)};
                        access(1'b1, op, a, sz, le[0], w, rule_tag(op));
                    end

        // R7: strobe low with accesses that would fault.
        access(1'b0, 1, 32'hDEAD_BEE3, 2, 1'b0, 32'h7C00_FFFF, "R7");
        access(1'b0, 3, 32'h0000_0000, 0, 1'b1, 32'hC123_4567, "R7");
        // R8: a lone fault followed by idle cycles yields one pulse.
        access(1'b1, 4, 32'h0000_1002, 2, 1'b0, 32'h7CA5_5A5A, "R3");
        access(1'b0, 0, 32'h0000_0000, 0, 1'b0, 32'h0, "R8");
        access(1'b1, 0, 32'h0000_2003, 3, 1'b0, 32'h8000_0001, "R4");
        // R9: all-ones displacement-form word.
        access(1'b1, 1, 32'h0000_0001, 2, 1'b0, 32'hFFFF_FFFF ^ 32'h2000_0000, "R9");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule